// File: doc/BRIEF.md
# Debug Register Bank Scan Chain

This block is a test-access data chain that lets a debug host reach a bank of up to 128 debug registers (breakpoint and watchpoint value and control words, vector catch) through a 7-bit address. Each scan carries three fields: a direction flag, a data word and an address. The chain does not return a result in the same scan that issues the request. Instead, a request is latched when the controller passes Update-DR, runs against the register bank in the background, and its result comes back on the next scan.

On the way out, the bit that carried the direction on the way in reports whether the chain is ready. The two fields behind it echo the previous request: its address, and either the value read or the value written. When a scan shows the chain still busy, the host repeats the same request until the ready bit reads 1. A closing dummy write to address 0 flushes out the last real result. Writes to address 0 never reach the bank, so this flush has no side effect.

The bank itself sits outside the block. It is reached through a simple port that holds a request until the bank signals completion.

Top module: `dbg_regchain`

## Requirements
- R1: After reset the first captured chain word has ready = 1, data = 0 and address = 0.
- R2: The chain is 40 bits long and shifts least significant bit first. Bit 0 is the direction/ready bit, bits 32:1 are the data word and bits 39:33 are the address. Every address from 0 to 127 is carried intact.
- R3: An Update-DR while ready is 1 latches the shifted request. In the next cycle regReq is 1, regAddr is the address field, regWdata is the data field, regWe is the direction bit (1 = write, 0 = read), and ready is 0.
- R4: An Update-DR while ready is 0 is ignored. The request in flight keeps its address, write enable and data, and the scan shows ready = 0.
- R5: In the cycle after regDone is sampled high with regReq, regReq is 0 and ready is 1. regReq and its address stay stable until regDone.
- R6: After a read completes, the next scan returns ready = 1, the read's address and the register value.
- R7: After a write completes, the next scan returns ready = 1, the write's address and the value written, and the bank holds that value.
- R8: A write to address 0 never raises regReq. It completes one cycle after it is latched, and the next scan echoes address 0 with the data that was shifted in. The bank word at address 0 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Active-low reset |
| captureDr | input | 1 | Capture-DR strobe for this chain |
| shiftDr | input | 1 | Shift-DR strobe for this chain |
| updateDr | input | 1 | Update-DR strobe for this chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| regReq | output | 1 | Register bank access request, held until regDone |
| regAddr | output | 7 | Register bank address |
| regWe | output | 1 | 1 for write, 0 for read |
| regWdata | output | 32 | Write data |
| regRdata | input | 32 | Read data, valid with regDone |
| regDone | input | 1 | Access complete |

## Verification
The bench uses the default 7-bit address and 32-bit data widths. Its bank model answers 50 TCK cycles after a request, which is longer than one 42-cycle scan. This makes a back-to-back scan capture ready = 0 and its Update-DR arrive while busy, so the ignore and rescan path is exercised along with the normal path. The full address width is exercised at both ends, at address 0 for the write-suppression rule and at address 127 for the top address bit.

// File: rtl/dbgchain_pkg.sv
package dbgchain_pkg;
  // Control-to-datapath strobes, one cycle each.
  typedef struct packed {
    logic capture;   // load {last address, last data, ready}
    logic shift;     // move one bit toward tdo
    logic latch;     // accept the shifted request
    logic complete;  // record the finished access
  } chainStrobes_t;
endpackage

// File: rtl/dbgchain_ctrl.sv
module dbgchain_ctrl
  import dbgchain_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          captureDr,
  input  logic          shiftDr,
  input  logic          updateDr,
  input  logic          flushReq,
  input  logic          regDone,
  output chainStrobes_t strobes,
  output logic          ready,
  output logic          regReq
);
  logic active;
  logic skipBank;

  always_comb begin
    strobes.capture  = captureDr;
    strobes.shift    = shiftDr;
    strobes.latch    = updateDr && ready;
    strobes.complete = active && (skipBank || regDone);
  end

  assign regReq = active && !skipBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready    <= 1'b1;
      active   <= 1'b0;
      skipBank <= 1'b0;
    end else if (strobes.latch) begin
      ready    <= 1'b0;
      active   <= 1'b1;
      skipBank <= flushReq;
    end else if (strobes.complete) begin
      ready    <= 1'b1;
      active   <= 1'b0;
      skipBank <= 1'b0;
    end
  end

  assert_latch_drops_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updateDr && ready) |=> !ready);
  assert_done_sets_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regDone) |=> (ready && !regReq));
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regDone) |=> regReq);
  assert_flush_no_bank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (updateDr && ready && flushReq) |=> !regReq);
  assert_flush_quick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && skipBank) |=> ready);
endmodule

// File: rtl/dbgchain_dp.sv
module dbgchain_dp
  import dbgchain_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobes_t     strobes,
  input  logic              ready,
  input  logic              tdi,
  output logic              tdo,
  output logic              flushReq,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);
  localparam int CHAIN_W = 1 + DATA_W + ADDR_W;
  localparam int DATA_LO = 1;
  localparam int ADDR_LO = 1 + DATA_W;

  logic [CHAIN_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  lastAddr;
  logic [DATA_W-1:0]  lastData;

  wire               inDir  = shiftReg[0];
  wire [DATA_W-1:0]  inData = shiftReg[ADDR_LO-1:DATA_LO];
  wire [ADDR_W-1:0]  inAddr = shiftReg[CHAIN_W-1:ADDR_LO];

  assign tdo      = shiftReg[0];
  assign flushReq = inDir && (inAddr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.capture) begin
      shiftReg <= {lastAddr, lastData, ready};
    end else if (strobes.shift) begin
      shiftReg <= {tdi, shiftReg[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr  <= '0;
      regWe    <= 1'b0;
      regWdata <= '0;
    end else if (strobes.latch) begin
      regAddr  <= inAddr;
      regWe    <= inDir;
      regWdata <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastData <= '0;
    end else if (strobes.complete) begin
      lastAddr <= regAddr;
      lastData <= regWe ? regWdata : regRdata;
    end
  end

  assert_capture_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (tdo == $past(ready)));
endmodule

// File: rtl/dbg_regchain.sv
module dbg_regchain
  import dbgchain_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic              regReq,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regDone
);
  chainStrobes_t strobes;
  logic          ready;
  logic          flushReq;

  dbgchain_ctrl i_ctrl (
    .clk(tck), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .flushReq(flushReq), .regDone(regDone),
    .strobes(strobes), .ready(ready), .regReq(regReq)
  );

  dbgchain_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(tck), .rstN(rstN), .strobes(strobes), .ready(ready), .tdi(tdi),
    .tdo(tdo), .flushReq(flushReq), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  assert_busy_ignores_update_R4: assert property (@(posedge tck) disable iff (!rstN)
    (updateDr && !ready) |=> ($stable(regAddr) && $stable(regWe) && $stable(regWdata)));
  assert_req_addr_stable_R5: assert property (@(posedge tck) disable iff (!rstN)
    (regReq && !regDone) |=> ($stable(regAddr) && $stable(regWe)));
endmodule

// File: tb/test_dbg_regchain.sv
module test_dbg_regchain;
  localparam int MODEL_LAT = 50;

  logic        tck = 1'b0;
  logic        rstN = 1'b0;
  logic        captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic        tdo, regReq, regWe;
  logic [6:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        regDone;

  int checks = 0;
  int errors = 0;

  always #2 tck = ~tck;  // 250 MHz

  dbg_regchain i_dbg_regchain (
    .tck(tck), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .regReq(regReq),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .regDone(regDone)
  );

  // Register bank model with fixed latency.
  function automatic logic [31:0] initVal(input int idx);
    return 32'h1000_0000 + idx * 32'h0001_0101;
  endfunction

  logic [31:0] mem [128];
  int          latCnt = 0;
  logic        doneR = 1'b0;
  assign regDone  = doneR;
  assign regRdata = mem[regAddr];

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = initVal(i);
  end

  always @(posedge tck) begin
    if (doneR) begin
      doneR <= 1'b0;
    end else if (regReq) begin
      if (latCnt == MODEL_LAT) begin
        doneR  <= 1'b1;
        latCnt <= 0;
        if (regWe) mem[regAddr] <= regWdata;
      end else begin
        latCnt <= latCnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doScan(input logic dir, input logic [31:0] d, input logic [6:0] a,
                        output logic [39:0] got);
    logic [39:0] tx;
    tx = {a, d, dir};
    @(negedge tck) captureDr = 1'b1;
    @(negedge tck) captureDr = 1'b0;
    shiftDr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi = tx[i];
      got[i] = tdo;
      @(negedge tck);
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge tck) updateDr = 1'b0;
  endtask

  task automatic checkEcho(input string req, input logic [39:0] got,
                           input logic rdy, input logic [31:0] d, input logic [6:0] a);
    check({req, " ready"}, 64'(got[0]), 64'(rdy));
    check({req, " data"},  64'(got[32:1]), 64'(d));
    check({req, " addr"},  64'(got[39:33]), 64'(a));
  endtask

  task automatic waitDone();
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge tck);
      if (regDone) begin seen = 1'b1; break; end
    end
    check("R5 done seen", 64'(seen), 64'(1));
    @(negedge tck);
    check("R5 req dropped after done", 64'(regReq), 64'(0));
  endtask

  task automatic scenarioResetAndRead();
    logic [39:0] got;
    doScan(1'b0, 32'h0, 7'd5, got);
    checkEcho("R1 reset word", got, 1'b1, 32'h0, 7'd0);
    check("R3 req raised", 64'(regReq), 64'(1));
    check("R3 addr latched", 64'(regAddr), 64'(5));
    check("R3 read dir", 64'(regWe), 64'(0));
  endtask

  task automatic scenarioBusyRetry();
    logic [39:0] got;
    doScan(1'b1, 32'hCAFE_1234, 7'd9, got);
    check("R4 busy ready=0", 64'(got[0]), 64'(0));
    check("R4 addr kept", 64'(regAddr), 64'(5));
    check("R4 dir kept", 64'(regWe), 64'(0));
    waitDone();
    doScan(1'b1, 32'hCAFE_1234, 7'd9, got);
    checkEcho("R6 read echo", got, 1'b1, initVal(5), 7'd5);
    check("R2 addr field", 64'(regAddr), 64'(9));
    check("R2 data field", 64'(regWdata), 64'(32'hCAFE_1234));
    check("R3 write dir", 64'(regWe), 64'(1));
    waitDone();
  endtask

  task automatic scenarioWriteEcho();
    logic [39:0] got;
    doScan(1'b0, 32'h0, 7'd9, got);
    checkEcho("R7 write echo", got, 1'b1, 32'hCAFE_1234, 7'd9);
    waitDone();
    doScan(1'b1, 32'hDEAD_0001, 7'd0, got);
    checkEcho("R7 bank updated", got, 1'b1, 32'hCAFE_1234, 7'd9);
    check("R8 no bank request", 64'(regReq), 64'(0));
  endtask

  task automatic scenarioFlush();
    logic [39:0] got;
    repeat (2) @(negedge tck);
    doScan(1'b0, 32'h0, 7'd0, got);
    checkEcho("R8 flush echo", got, 1'b1, 32'hDEAD_0001, 7'd0);
    check("R8 read addr0 reaches bank", 64'(regReq), 64'(1));
    waitDone();
    doScan(1'b1, 32'h0, 7'd0, got);
    checkEcho("R8 addr0 unchanged", got, 1'b1, initVal(0), 7'd0);
    repeat (2) @(negedge tck);
  endtask

  task automatic scenarioTopAddr();
    logic [39:0] got;
    doScan(1'b0, 32'h0, 7'd127, got);
    checkEcho("R2 after flush", got, 1'b1, 32'h0, 7'd0);
    check("R2 top addr", 64'(regAddr), 64'(127));
    waitDone();
    doScan(1'b1, 32'h0, 7'd0, got);
    checkEcho("R2 top addr echo", got, 1'b1, initVal(127), 7'd127);
    repeat (2) @(negedge tck);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    rstN = 1'b1;
    @(negedge tck);
    check("R5 idle no req", 64'(regReq), 64'(0));
    scenarioResetAndRead();
    scenarioBusyRetry();
    scenarioWriteEcho();
    scenarioFlush();
    scenarioTopAddr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule